// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures how long one cycle of a low-frequency clock lasts, using a fast reference clock as the ruler. A controller picks one of four slow sources and a number of slow cycles to observe, then pulses a start request. Every slow input is brought into the reference domain by a synchroniser, and its rising edges are detected there. The block counts reference cycles between the first detected slow rising edge and the edge that closes the requested number of slow cycles. It then divides that count by the cycle count and reports the average slow period in reference cycles, as an unsigned value with 19 fractional bits.

A slow source that has stopped is caught by a timeout. The limit is the requested cycle count shifted left by an amount that depends on the source. When the limit is reached first, the run ends with a zero result and a timeout flag. In one-shot mode a single measurement is made. In cycling mode a new measurement starts as soon as each one finishes, and the output always holds the most recent result.

Top module: `slow_clk_calibrator`

## Requirements
- R1: The select input chooses the measured input: code 0 is the current slow-clock mux output, code 1 is the 8 MHz oscillator divided by 256, code 2 is the external 32 kHz crystal, and code 3 is the internal low-speed oscillator. These are bits 0 to 3 of the slow clock input vector.
- R2: The result is an unsigned 32-bit value with 19 fractional bits, equal to floor((reference count << 19) / requested cycles). A slow clock with a steady period of P reference cycles therefore gives exactly P * 2^19.
- R3: Counting starts at the first synchronised slow rising edge after start. The phase of the slow clock at start has no effect on the result.
- R4: The timeout limit is the requested cycle count shifted left by 12 for codes 1 and 2, and shifted left by 10 for codes 0 and 3. With the start sampled at clock edge 0, a source that never rises produces the timeout at edge limit+1.
- R5: On a timeout the result reads 0, the timeout flag rises, done pulses and busy falls.
- R6: In one-shot mode (cycle mode input 0), busy falls in the same cycle that done pulses, and the block then stays idle.
- R7: In cycling mode (cycle mode input 1), busy stays high and a new measurement begins after each done. A run that finishes while the cycle mode input is low ends the sequence.
- R8: A start request while busy is ignored. The running measurement keeps its source and cycle count.
- R9: A start request with a requested cycle count of 0 is ignored, and busy stays low.
- R10: Done is a one-cycle pulse. The timeout flag holds until the next accepted start.
- R11: After reset, busy, done and timeout are low and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk_i | input | 4 | Asynchronous slow clock sources, indexed by select code |
| start_i | input | 1 | Start request, sampled when idle |
| src_sel_i | input | 2 | Source select code |
| cycles_i | input | 16 | Number of slow cycles to measure |
| cyc_mode_i | input | 1 | 0 one-shot, 1 cycling |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle pulse at the end of each run |
| timeout_o | output | 1 | Last run ended by timeout |
| result_o | output | 32 | Average slow period, 19 fractional bits |

## Verification
The assertions check on every cycle that done lasts only one cycle and that a timeout always shows a zero result. They also check that busy falls only together with done, that the elapsed-cycle counter never passes the source's limit, and that start requests arriving while busy or with a zero count change nothing. Only the bench scenarios can show the measured values themselves. These are the exact period fractions for each source, the result being independent of the start phase, the exact timeout latency for the short and long shifts, and a cycling run picking up a period change and then stopping cleanly.

// File: rtl/slowcal_pkg.sv
// Shared types and select codes for the slow clock calibration counter.
package slowcal_pkg;

    // Width of the source select field and the number of sources it spans.
    localparam int CAL_SEL_W = 2;
    localparam int CAL_NSRC  = 1 << CAL_SEL_W;

    // Select codes; codes 1 and 2 are the slow-ticking sources with the long timeout shift.
    localparam logic [CAL_SEL_W-1:0] SRC_MUX     = 2'd0;
    localparam logic [CAL_SEL_W-1:0] SRC_RC_DIV  = 2'd1;
    localparam logic [CAL_SEL_W-1:0] SRC_XTAL32  = 2'd2;
    localparam logic [CAL_SEL_W-1:0] SRC_INT_OSC = 2'd3;

    // Control states of the measurement sequencer.
    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_ARM  = 2'd1,
        CAL_MEAS = 2'd2,
        CAL_DIV  = 2'd3
    } cal_state_e;

endpackage

// File: rtl/slowcal_edge_sync.sv
// Brings one asynchronous slow clock into the reference domain through two
// flops and flags each rising edge with a one-cycle pulse.
// Assumes the slow clock's high and low phases each last at least two
// reference cycles.
module slowcal_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-flop synchroniser plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // A rise is a synchronised high that was low one cycle earlier.
    always_comb rise = sync_q & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R3

endmodule

// File: rtl/slowcal_divider.sv
// Restoring divider that produces one quotient bit per cycle.
// Assumes a nonzero divisor; after go, valid pulses NUM_W cycles later with
// the low Q_W bits of the quotient.
module slowcal_divider #(
    parameter int NUM_W = 47,
    parameter int DEN_W = 16,
    parameter int Q_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             valid,
    output logic [Q_W-1:0]   quot
);

    localparam int STEP_W = $clog2(NUM_W + 1);

    logic              run_q;
    logic [STEP_W-1:0] step_q;
    logic [DEN_W-1:0]  rem_q;
    logic [NUM_W-1:0]  q_q;
    logic [DEN_W-1:0]  dsr_q;
    logic [DEN_W:0]    shifted;
    logic              fits;
    logic [DEN_W-1:0]  rem_nx;

    // One trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {rem_q, q_q[NUM_W-1]};
        fits    = shifted >= {1'b0, dsr_q};
        rem_nx  = fits ? DEN_W'(shifted - {1'b0, dsr_q}) : DEN_W'(shifted);
    end

    // Iteration control: load on go, then one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            step_q <= '0;
            rem_q  <= '0;
            q_q    <= '0;
            dsr_q  <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                run_q  <= 1'b1;
                step_q <= '0;
                rem_q  <= '0;
                q_q    <= num;
                dsr_q  <= den;
            end else if (run_q) begin
                rem_q  <= rem_nx;
                q_q    <= {q_q[NUM_W-2:0], fits};
                step_q <= step_q + 1'b1;
                if (step_q == STEP_W'(NUM_W - 1)) begin
                    run_q <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    // The quotient is taken from the low bits once the shift register is full.
    always_comb quot = q_q[Q_W-1:0];

    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (rem_q < dsr_q)); // R2

endmodule

// File: rtl/slow_clk_calibrator.sv
// Top level of the slow clock calibration counter.
// Synchronises every slow source, counts reference cycles over the requested
// number of slow cycles of the selected source, applies a per-source timeout,
// and divides to obtain the average period as a fraction with FRAC_W bits.
// Assumes each slow clock phase lasts at least two reference cycles.
module slow_clk_calibrator
    import slowcal_pkg::*;
#(
    parameter int CYC_W       = 16,
    parameter int RES_W       = 32,
    parameter int FRAC_W      = 19,
    parameter int SHIFT_LONG  = 12,
    parameter int SHIFT_SHORT = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CAL_NSRC-1:0]  slow_clk_i,
    input  logic                 start_i,
    input  logic [CAL_SEL_W-1:0] src_sel_i,
    input  logic [CYC_W-1:0]     cycles_i,
    input  logic                 cyc_mode_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 timeout_o,
    output logic [RES_W-1:0]     result_o
);

    localparam int CNT_W  = CYC_W + SHIFT_LONG;
    localparam int TICK_W = CNT_W + 1;
    localparam int NUM_W  = CNT_W + FRAC_W;

    cal_state_e           state_q;
    logic [CAL_SEL_W-1:0] sel_q;
    logic [CYC_W-1:0]     cyc_q;
    logic [TICK_W-1:0]    tick_q;
    logic [CNT_W-1:0]     ref_q;
    logic [CYC_W-1:0]     edge_q;
    logic [NUM_W-1:0]     num_q;
    logic                 go_q;
    logic [CAL_NSRC-1:0]  rise_vec;
    logic                 rise_sel;
    logic                 long_src;
    logic [TICK_W-1:0]    limit;
    logic                 last_edge;
    logic                 expired;
    logic                 accept;
    logic                 div_valid;
    logic [RES_W-1:0]     div_quot;

    // One synchroniser per source, so switching the select never creates a false edge.
    genvar g;
    generate
        for (g = 0; g < CAL_NSRC; g++) begin : g_sync
            slowcal_edge_sync u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (slow_clk_i[g]),
                .rise     (rise_vec[g])
            );
        end
    endgenerate

    // Source pick, per-source timeout limit and end-of-window decode.
    always_comb begin
        rise_sel  = rise_vec[sel_q];
        long_src  = (sel_q == SRC_RC_DIV) || (sel_q == SRC_XTAL32);
        limit     = long_src ? (TICK_W'(cyc_q) << SHIFT_LONG)
                             : (TICK_W'(cyc_q) << SHIFT_SHORT);
        last_edge = rise_sel && (({1'b0, edge_q} + 1'b1) == {1'b0, cyc_q});
        expired   = (tick_q == limit);
        accept    = start_i && (cycles_i != '0);
    end

    // Sequencer: arm, measure, divide, then stop or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= CAL_IDLE;
            sel_q     <= '0;
            cyc_q     <= '0;
            tick_q    <= '0;
            ref_q     <= '0;
            edge_q    <= '0;
            num_q     <= '0;
            go_q      <= 1'b0;
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            result_o  <= '0;
        end else begin
            done_o <= 1'b0;
            go_q   <= 1'b0;
            case (state_q)
                CAL_IDLE: begin
                    if (accept) begin
                        state_q   <= CAL_ARM;
                        sel_q     <= src_sel_i;
                        cyc_q     <= cycles_i;
                        tick_q    <= '0;
                        edge_q    <= '0;
                        busy_o    <= 1'b1;
                        timeout_o <= 1'b0;
                    end
                end
                CAL_ARM: begin
                    tick_q <= tick_q + 1'b1;
                    if (rise_sel) begin
                        state_q <= CAL_MEAS;
                        ref_q   <= '0;
                    end else if (expired) begin
                        state_q   <= CAL_IDLE;
                        busy_o    <= 1'b0;
                        done_o    <= 1'b1;
                        timeout_o <= 1'b1;
                        result_o  <= '0;
                    end
                end
                CAL_MEAS: begin
                    tick_q <= tick_q + 1'b1;
                    ref_q  <= ref_q + 1'b1;
                    if (last_edge) begin
                        num_q   <= {CNT_W'(ref_q + 1'b1), {FRAC_W{1'b0}}};
                        go_q    <= 1'b1;
                        state_q <= CAL_DIV;
                    end else if (expired) begin
                        state_q   <= CAL_IDLE;
                        busy_o    <= 1'b0;
                        done_o    <= 1'b1;
                        timeout_o <= 1'b1;
                        result_o  <= '0;
                    end else if (rise_sel) begin
                        edge_q <= edge_q + 1'b1;
                    end
                end
                CAL_DIV: begin
                    if (div_valid) begin
                        result_o <= div_quot;
                        done_o   <= 1'b1;
                        if (cyc_mode_i) begin
                            state_q <= CAL_ARM;
                            tick_q  <= '0;
                            edge_q  <= '0;
                        end else begin
                            state_q <= CAL_IDLE;
                            busy_o  <= 1'b0;
                        end
                    end
                end
                default: state_q <= CAL_IDLE;
            endcase
        end
    end

    slowcal_divider #(
        .NUM_W (NUM_W),
        .DEN_W (CYC_W),
        .Q_W   (RES_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go_q),
        .num   (num_q),
        .den   (cyc_q),
        .valid (div_valid),
        .quot  (div_quot)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (result_o == '0)); // R5
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(sel_q) && $stable(cyc_q))); // R8
    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (tick_q <= limit)); // R4
    AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (cycles_i == '0)) |=> !busy_o); // R9

endmodule

// File: tb/slow_clk_calibrator_bench.sv
module slow_clk_calibrator_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  slow_clk;
    logic        start;
    logic [1:0]  src_sel;
    logic [15:0] cycles;
    logic        cyc_mode;
    logic        busy_o;
    logic        done_o;
    logic        timeout_o;
    logic [31:0] result_o;

    int checks   = 0;
    int failures = 0;
    int hi_len[4];
    int lo_len[4];
    int ph[4];
    bit frz[4];

    always #2 clk = ~clk;

    slow_clk_calibrator u_slow_clk_calibrator (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_clk_i (slow_clk),
        .start_i    (start),
        .src_sel_i  (src_sel),
        .cycles_i   (cycles),
        .cyc_mode_i (cyc_mode),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .timeout_o  (timeout_o),
        .result_o   (result_o)
    );

    // Slow clock generators, advanced on the falling reference edge.
    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (frz[k]) begin
                slow_clk[k] <= 1'b0;
                ph[k]       <= 0;
            end else if (ph[k] + 1 >= (slow_clk[k] ? hi_len[k] : lo_len[k])) begin
                slow_clk[k] <= ~slow_clk[k];
                ph[k]       <= 0;
            end else begin
                ph[k] <= ph[k] + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_run(input logic [1:0] sel, input logic [15:0] n, input logic mode);
        @(negedge clk);
        src_sel  = sel;
        cycles   = n;
        cyc_mode = mode;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int max, output int lat, output bit got);
        lat = 0;
        got = 1'b0;
        while (lat < max && !got) begin
            @(posedge clk);
            lat++;
            #1;
            if (done_o) got = 1'b1;
        end
    endtask

    task automatic t_reset;
        chk("R11 busy", busy_o, 0);
        chk("R11 done", done_o, 0);
        chk("R11 timeout", timeout_o, 0);
        chk("R11 result", result_o, 0);
    endtask

    task automatic t_oneshot(input logic [1:0] sel, input logic [15:0] n, input int period,
                             input int gap, input string req);
        int lat;
        bit got;
        repeat (gap) @(negedge clk);
        start_run(sel, n, 1'b0);
        wait_done(3000, lat, got);
        chk({req, " done seen"}, got, 1);
        chk({req, " R2 period fraction"}, result_o, 64'(period) << 19);
        chk({req, " timeout low"}, timeout_o, 0);
        chk("R6 busy low with done", busy_o, 0);
    endtask

    task automatic t_timeout(input logic [1:0] sel, input logic [15:0] n, input int shift);
        int lat;
        bit got;
        frz[sel] = 1'b1;
        repeat (10) @(negedge clk);
        start_run(sel, n, 1'b0);
        wait_done(10000, lat, got);
        chk("R4 timeout latency", lat, (int'(n) << shift) + 1);
        chk("R5 timeout flag", timeout_o, 1);
        chk("R5 result zero", result_o, 0);
        chk("R5 busy low", busy_o, 0);
        repeat (5) @(posedge clk);
        #1;
        chk("R10 timeout held", timeout_o, 1);
        chk("R10 done pulse ended", done_o, 0);
        frz[sel] = 1'b0;
    endtask

    task automatic t_ignore;
        int lat;
        bit got;
        start_run(2'd0, 16'd4, 1'b0);
        repeat (8) @(negedge clk);
        src_sel = 2'd1;
        cycles  = 16'd1;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(3000, lat, got);
        chk("R8 first run done", got, 1);
        chk("R8 original source kept", result_o, 64'(10) << 19);
        wait_done(150, lat, got);
        chk("R8 no second run", got, 0);
        chk("R8 idle after", busy_o, 0);
    endtask

    task automatic t_zero;
        int lat;
        bit got;
        start_run(2'd0, 16'd0, 1'b0);
        #1;
        chk("R9 busy stays low", busy_o, 0);
        wait_done(60, lat, got);
        chk("R9 no done", got, 0);
    endtask

    task automatic t_cycling;
        int lat;
        bit got;
        start_run(2'd0, 16'd2, 1'b1);
        wait_done(3000, lat, got);
        chk("R7 first cycling result", result_o, 64'(10) << 19);
        chk("R7 busy held", busy_o, 1);
        @(negedge clk);
        hi_len[0] = 6;
        lo_len[0] = 6;
        wait_done(3000, lat, got);
        chk("R7 second run done", got, 1);
        chk("R7 busy held again", busy_o, 1);
        wait_done(3000, lat, got);
        chk("R7 updated result", result_o, 64'(12) << 19);
        @(negedge clk);
        cyc_mode = 1'b0;
        wait_done(3000, lat, got);
        chk("R7 final run done", got, 1);
        chk("R7 final result", result_o, 64'(12) << 19);
        chk("R7 stops when mode low", busy_o, 0);
        wait_done(150, lat, got);
        chk("R7 no restart", got, 0);
    endtask

    initial begin
        #(4 * 190000);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        slow_clk = 4'b0;
        hi_len = '{5, 3, 12, 4};
        lo_len = '{5, 4, 12, 5};
        ph     = '{0, 0, 0, 0};
        frz    = '{0, 0, 0, 0};
        start    = 1'b0;
        src_sel  = 2'd0;
        cycles   = 16'd0;
        cyc_mode = 1'b0;
        rst_n    = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_oneshot(2'd1, 16'd3, 7, 0, "R1 src1 R3 phase a");
        t_oneshot(2'd1, 16'd3, 7, 2, "R1 src1 R3 phase b");
        t_oneshot(2'd1, 16'd3, 7, 5, "R1 src1 R3 phase c");
        t_oneshot(2'd0, 16'd5, 10, 1, "R1 src0");
        t_oneshot(2'd2, 16'd2, 24, 3, "R1 src2");
        t_oneshot(2'd3, 16'd1, 9, 0, "R1 src3");
        t_timeout(2'd3, 16'd2, 10);
        t_timeout(2'd2, 16'd1, 12);
        t_oneshot(2'd0, 16'd2, 10, 1, "R10 timeout cleared");
        t_ignore();
        t_zero();
        t_cycling();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule